// File: doc/BRIEF.md
# Timer Bank with Interrupt Aggregator

This block holds three free-running up-counting timers, each 30 bits wide, and a small interrupt aggregator. A timer is started with one control word: a target value, a rearm flag and an enable flag. When an enabled timer's count reaches its target, the timer records a pending event. With the rearm flag set, the count then returns to zero and keeps running. With the flag clear, the timer stops and turns its own enable off.

Pending events from all timers are kept in one status byte. One more status bit, just above the timer bits, records rising edges on an external watchdog-warning pin. Software masks the timer events with an enable byte and clears pending bits by writing ones. The block drives one registered, level-sensitive interrupt line. That line is high when any enabled timer event is pending, or when a watchdog event is pending. The enable byte cannot mask the watchdog event.

Software reaches the block through a plain synchronous register port. It takes a word index, a write strobe, byte-lane enables and 32-bit write data. Read data is combinational from the word index. The port never stalls: every write is taken on the clock edge where the strobe is high, so the port has no back-pressure and no valid/ready handshake.

Top module: `tmr_irq_bank`

## Requirements
- R1: After reset every control word, count, enable bit and status bit is zero, and `irq_o` is low.
- R2: Word 0 holds the enable bits in bits 18:16 (timer i at bit 16+i) and the status bits in bits 27:24 (timer i at bit 24+i, watchdog at bit 27). Words 1 to 3 are the control words of timers 0 to 2. Words 4 to 6 are their counts. In a control word, bits 29:0 are the target, bit 30 is rearm and bit 31 is enable.
- R3: An enabled timer whose count differs from its target adds one to its count on every clock. Count words read zero in bits 31:30.
- R4: When an enabled timer's count equals its target, its status bit is set on the next edge. With rearm set, the count returns to 0 on that same edge, so the event repeats every target+1 clocks.
- R5: With rearm clear, the event edge clears the timer's enable bit, and the count holds at the target.
- R6: Writing 1 to a status bit through byte lane 3 clears it. Writing 0 leaves it unchanged.
- R7: `irq_o` is a register. One clock after the status and enable state changes, it equals the OR over the timers of (status AND enable), ORed with the watchdog status bit.
- R8: A rising edge on `wdog_warn_i` sets status bit 27. A level that stays high does not set the bit again after it is cleared.
- R9: The watchdog event raises `irq_o` whatever the enable bits hold. Bit 19 of word 0 always reads 0, and writing it has no effect.
- R10: If a hardware event and a software clear reach the same status bit on the same edge, the bit ends up set.
- R11: Only byte lanes whose `bus_be` bit is 1 are written. The other bytes of the addressed register keep their values.
- R12: Writing a count word loads that count. Writing 0 to a control word stops the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | 4 | Word index (byte address divided by 4) |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word`, combinational |
| wdog_warn_i | input | 1 | Watchdog warning level; its rising edge raises an event |
| irq_o | output | 1 | Aggregated level interrupt |

## Verification
Two actions can land on the same status bit on the same edge. A hardware event, either a timer reaching its target or a watchdog rising edge, can set it while a software write-one-to-clear clears it. The bench provokes this on the watchdog bit, because the edge that bit sees can be placed exactly. It drives the pin low to high in the same cycle as a clear write of bit 27, then reads the status word and expects the bit to still be set. The same kind of collision between a control write and a timer event happens during the stop sequence, and there the bench judges it by the status reading clear after the final write-one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 30;

  typedef struct packed {
    logic             en;
    logic             rearm;
    logic [CNT_W-1:0] target;
  } ctl_t;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = be[b/8] ? new_v[b] : old_v[b];
    return r;
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  ctl_t             ctl_wval,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wval,
  output ctl_t             ctl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit_o
);
  assign hit_o = ctl_q.en && (cnt_q == ctl_q.target);

  always_ff @(posedge clk) begin
    if (!rst_n)                       ctl_q <= '0;
    else if (ctl_wr)                  ctl_q <= ctl_wval;
    else if (hit_o && !ctl_q.rearm)   ctl_q.en <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_wr)     cnt_q <= cnt_wval;
    else if (hit_o) begin
      if (ctl_q.rearm)   cnt_q <= '0;
    end
    else if (ctl_q.en)   cnt_q <= cnt_q + 1'b1;
  end

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && !hit_o && !cnt_wr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_rearm_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && ctl_q.rearm && !cnt_wr) |=> (cnt_q == '0));

  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !ctl_q.rearm && !ctl_wr && !cnt_wr) |=> (!ctl_q.en && $stable(cnt_q)));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg #(
  parameter int NUM_TMR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic [NUM_TMR-1:0] en_wval,
  input  logic               clr_wr,
  input  logic [NUM_TMR:0]   clr_mask,
  input  logic [NUM_TMR-1:0] hit,
  input  logic               wdog_in,
  output logic [NUM_TMR-1:0] en_q,
  output logic [NUM_TMR:0]   st_q,
  output logic               irq_o
);
  localparam int WD_BIT = NUM_TMR;

  logic             wd_q;
  logic             wd_rise;
  logic [NUM_TMR:0] set_v;

  assign wd_rise = wdog_in && !wd_q;
  assign set_v   = {wd_rise, hit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      wd_q <= 1'b0;
    end else begin
      wd_q <= wdog_in;
      if (en_wr) en_q <= en_wval;
    end
  end

  for (genvar b = 0; b <= NUM_TMR; b++) begin : g_st
    always_ff @(posedge clk) begin
      if (!rst_n)                      st_q[b] <= 1'b0;
      else if (set_v[b])               st_q[b] <= 1'b1;
      else if (clr_wr && clr_mask[b])  st_q[b] <= 1'b0;
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[b] |=> st_q[b]);

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_mask[b] && !set_v[b]) |=> !st_q[b]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= (|(st_q[NUM_TMR-1:0] & en_q)) || st_q[WD_BIT];
  end

  p_wdog_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[WD_BIT] |=> irq_o);

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(st_q[NUM_TMR-1:0] & en_q)) && !st_q[WD_BIT]) |=> !irq_o);

  p_level_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_q && wdog_in) |-> !wd_rise);
endmodule

// File: rtl/tmr_irq_bank.sv
module tmr_irq_bank
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 3,
  parameter int WORD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_word,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wdog_warn_i,
  output logic              irq_o
);
  localparam int CTL_BASE = 1;
  localparam int CNT_BASE = CTL_BASE + NUM_TMR;
  localparam int EN_LSB   = 16;
  localparam int ST_LSB   = 24;

  ctl_t             ctl_q   [NUM_TMR];
  logic [CNT_W-1:0] cnt_q   [NUM_TMR];
  logic [NUM_TMR-1:0] ctl_wr, cnt_wr, hit;
  logic [NUM_TMR-1:0] en_q;
  logic [NUM_TMR:0]   st_q;
  logic               ctl_page, en_wr, clr_wr;

  assign ctl_page = bus_wr && (bus_word == '0);
  assign en_wr    = ctl_page && bus_be[EN_LSB/8];
  assign clr_wr   = ctl_page && bus_be[ST_LSB/8];

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    ctl_t             ctl_mrg;
    logic [31:0]      cnt_full;
    logic [CNT_W-1:0] cnt_mrg;

    assign ctl_wr[i] = bus_wr && (|bus_be) && (bus_word == WORD_W'(CTL_BASE + i));
    assign cnt_wr[i] = bus_wr && (|bus_be) && (bus_word == WORD_W'(CNT_BASE + i));
    assign ctl_mrg   = ctl_t'(lane_merge(ctl_q[i], bus_wdata, bus_be));
    assign cnt_full  = lane_merge({{(32-CNT_W){1'b0}}, cnt_q[i]}, bus_wdata, bus_be);
    assign cnt_mrg   = cnt_full[CNT_W-1:0];

    tmr_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr[i]),
      .ctl_wval (ctl_mrg),
      .cnt_wr   (cnt_wr[i]),
      .cnt_wval (cnt_mrg),
      .ctl_q    (ctl_q[i]),
      .cnt_q    (cnt_q[i]),
      .hit_o    (hit[i])
    );
  end

  tmr_irq_agg #(.NUM_TMR(NUM_TMR)) u_agg (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (en_wr),
    .en_wval  (bus_wdata[EN_LSB +: NUM_TMR]),
    .clr_wr   (clr_wr),
    .clr_mask (bus_wdata[ST_LSB +: NUM_TMR+1]),
    .hit      (hit),
    .wdog_in  (wdog_warn_i),
    .en_q     (en_q),
    .st_q     (st_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_word == '0) begin
      bus_rdata[EN_LSB +: NUM_TMR]   = en_q;
      bus_rdata[ST_LSB +: NUM_TMR+1] = st_q;
    end
    for (int i = 0; i < NUM_TMR; i++) begin
      if (bus_word == WORD_W'(CTL_BASE + i)) bus_rdata = ctl_q[i];
      if (bus_word == WORD_W'(CNT_BASE + i)) bus_rdata[CNT_W-1:0] = cnt_q[i];
    end
  end

  p_rd_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word >= WORD_W'(CNT_BASE) && bus_word < WORD_W'(CNT_BASE + NUM_TMR))
      |-> (bus_rdata[31:CNT_W] == '0));

  p_lane_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr[0] && !bus_be[3]) |=> (ctl_q[0].en == $past(ctl_q[0].en) || $past(hit[0])));
endmodule

// File: tb/tmr_irq_bank_tb_top.sv
module tmr_irq_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_word = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdog_warn = 1'b0;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdog_warn_i(wdog_warn), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_word = w; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] w, output logic [31:0] d);
    bus_word = w;
    #1;
    d = bus_rdata;
  endtask

  task automatic stop_tmr(input int t);
    wr(4'(1 + t), 4'hF, 32'h0);
    wr(4'(4 + t), 4'hF, 32'h0);
    wr(4'd0, 4'b1000, 32'h1 << (24 + t));
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state over every word
    for (int w = 0; w < 7; w++) begin
      rd(4'(w), v);
      chk($sformatf("R1 word %0d", w), v, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R4 R5 R3 R7 R2: sweep timers, targets and rearm
    for (int t = 0; t < 3; t++) begin
      for (int rc = 0; rc < 2; rc++) begin
        for (int tg = 0; tg < 6; tg++) begin
          stop_tmr(t);
          wr(4'd0, 4'b0100, 32'h1 << (16 + t));
          wr(4'(1 + t), 4'hF, (32'h1 << 31) | (32'(rc) << 30) | 32'(tg));
          rd(4'd0, v);
          chk("R4 status before", v[31:24], 32'h0);
          for (int j = 1; j <= tg + 1; j++) begin
            @(negedge clk);
            rd(4'd0, v);
            chk("R4 status", {24'h0, v[31:24]}, (j == tg + 1) ? (32'h1 << t) : 32'h0);
            chk("R7 irq lag", {31'h0, irq}, 32'h0);
            rd(4'(4 + t), v);
            chk("R3 count", v, (j <= tg) ? 32'(j) : (rc != 0 ? 32'h0 : 32'(tg)));
          end
          @(negedge clk);
          chk("R7 irq set", {31'h0, irq}, 32'h1);
          rd(4'(1 + t), v);
          chk(rc != 0 ? "R4 enable kept" : "R5 enable cleared", v,
              (rc != 0) ? ((32'h3 << 30) | 32'(tg)) : 32'(tg));
          rd(4'(4 + t), v);
          chk(rc != 0 ? "R4 rerun" : "R5 hold", v, (rc != 0 && tg > 0) ? 32'h1 : 32'(tg));
        end
      end
      stop_tmr(t);
    end
    repeat (2) @(negedge clk);
    chk("R12 stopped irq", {31'h0, irq}, 32'h0);

    // R7 masked event, R6 write zero
    wr(4'd0, 4'b0100, 32'h0);
    wr(4'd1, 4'hF, 32'h8000_0002);
    repeat (6) @(negedge clk);
    rd(4'd0, v);
    chk("R7 masked status", v, 32'h0100_0000);
    chk("R7 masked irq", {31'h0, irq}, 32'h0);
    wr(4'd0, 4'b1000, 32'h0);
    rd(4'd0, v);
    chk("R6 write zero keeps", v, 32'h0100_0000);

    // R11 R9: lane 2 only; watchdog enable position ignored
    wr(4'd0, 4'b0100, 32'hFF0F_0000);
    rd(4'd0, v);
    chk("R11 R9 lane2 only", v, 32'h0107_0000);
    chk("R7 irq after enable pre", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq after enable", {31'h0, irq}, 32'h1);
    wr(4'd0, 4'b1000, 32'h0100_0000);
    rd(4'd0, v);
    chk("R6 w1c", v, 32'h0007_0000);
    wr(4'd0, 4'b0100, 32'h0);

    // R11 on a control word
    wr(4'd2, 4'b0001, 32'hFFFF_FF12);
    rd(4'd2, v);
    chk("R11 ctl lane0", v, 32'h0000_0012);

    // R12 count load, R3 upper bits
    wr(4'd5, 4'hF, 32'hFFFF_FFFF);
    rd(4'd5, v);
    chk("R3 count upper zero", v, 32'h3FFF_FFFF);
    wr(4'd5, 4'hF, 32'd100);
    rd(4'd5, v);
    chk("R12 count load", v, 32'd100);
    wr(4'd2, 4'hF, 32'h8000_0000 | 32'd105);
    repeat (10) @(negedge clk);
    rd(4'd0, v);
    chk("R12 loaded run status", v, 32'h0200_0000);
    rd(4'd5, v);
    chk("R5 loaded run hold", v, 32'd105);
    stop_tmr(1);
    stop_tmr(0);

    // R8 R9 watchdog edge, unmaskable
    @(negedge clk);
    wdog_warn = 1'b1;
    @(negedge clk);
    rd(4'd0, v);
    chk("R8 wdog status", v, 32'h0800_0000);
    chk("R9 irq pre", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 wdog irq unmasked", {31'h0, irq}, 32'h1);
    wr(4'd0, 4'b1000, 32'h0800_0000);
    repeat (2) @(negedge clk);
    rd(4'd0, v);
    chk("R8 level no reset", v, 32'h0);
    chk("R8 irq drops", {31'h0, irq}, 32'h0);

    // R10 set and clear on the same edge
    wdog_warn = 1'b0;
    repeat (2) @(negedge clk);
    wdog_warn = 1'b1;
    bus_word = 4'd0; bus_be = 4'b1000; bus_wdata = 32'h0800_0000; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(4'd0, v);
    chk("R10 set wins", v, 32'h0800_0000);
    wr(4'd0, 4'b1000, 32'h0800_0000);
    rd(4'd0, v);
    chk("R6 clear after", v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule